// File: doc/BRIEF.md
# Rate Driven Partition Switch Controller

This block selects which of three hardware/software splits of a peak-counting datapath should be resident in reconfigurable logic. The split is chosen from the most recent measured peak rate. A rate monitor presents a rate word with a one-cycle strobe. The controller keeps the latest value and compares it against two programmable thresholds. Partition 1 puts all logic in hardware and is used for fast peak streams. Partition 3 keeps only the comparator in hardware and is used for slow streams. Partition 2 is the mixed split between them.

A change of partition is started only on a load-boundary strobe, which marks the end of a fixed computation window. Reconfiguration is modelled by a countdown. Its length is a fixed overhead plus a per-byte time for each configuration byte that the chosen transition moves. Both times are given in nanoseconds and converted to clock cycles from a clock-period parameter. When the countdown ends, the new partition is reported. The logic is enabled only at the next boundary, so its inputs are stable before it runs. Across all of this the block integrates a time-weighted "rent" area of the configurable logic it occupies.

Top module: `part_switch_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the partition output reads 1, busy is 0, enable is 1 and the rent accumulator is 0.
- R2: Partition codes on `part_o` are 1 = all logic in hardware, 2 = mixed, 3 = comparator only. With the latched rate r, the target is 1 when r >= high threshold, 2 when low <= r < high, and 3 when r < low.
- R3: A switch starts only at a clock edge where the block is idle, `load_bound` is high, the thresholds are valid and the target differs from the current partition. In every other case busy stays 0 and the partition is held.
- R4: A switch keeps the old partition on `part_o` for OVH + B*BPC cycles from its start edge and then shows the new one. OVH and BPC are the overhead and per-byte times rounded up to whole clocks. B is 30 between 1 and 2, 11 between 2 and 3, and 43 between 1 and 3, in either direction.
- R5: Busy rises at the start edge and falls at the first `load_bound` edge after the countdown ends. `enable_o` is the inverse of busy.
- R6: A rate strobe during a switch updates the latched rate but does not redirect or restart that switch. The new rate takes effect at the first boundary after the switch completes.
- R7: When the low threshold is not below the high threshold, no switch starts.
- R8: Each cycle the rent accumulator adds the area of the current partition (71, 41, 30 bytes for 1, 2, 3). While busy it adds the larger of the source and destination areas.
- R9: When a rate strobe and a load boundary arrive in the same cycle, the decision at that boundary uses the previously latched rate.
- R10: A load boundary during the countdown neither ends nor lengthens it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_in | input | RATE_W | Measured peak rate |
| rate_stb | input | 1 | Latch `rate_in` this cycle |
| thr_lo | input | RATE_W | Low rate threshold |
| thr_hi | input | RATE_W | High rate threshold |
| load_bound | input | 1 | Computation-window boundary strobe |
| part_o | output | 2 | Current resident partition (1, 2, 3) |
| busy_o | output | 1 | Switch in progress |
| enable_o | output | 1 | Resident logic may compute |
| rent_o | output | ACC_W | Time-weighted area accumulator |

## Verification
Two events can coincide: a rate strobe and the load boundary that decides a switch. The bench drives both in one cycle while the latched rate still points at the current partition, but the new rate points elsewhere. It expects busy to stay low at the next sample, and a switch to follow only at the next boundary. A second overlap puts a boundary and a rate strobe inside the countdown of a switch. The bench then checks the exact cycle of the partition change, the busy interval and the rent total against values computed from the transition's byte count.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [1:0] {
    P_NONE = 2'd0,
    P_HW   = 2'd1,
    P_MIX  = 2'd2,
    P_SW   = 2'd3
  } part_t;

  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_LOAD = 2'd1,
    PH_ARM  = 2'd2
  } phase_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/psc_decide.sv
module psc_decide
  import psc_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate_in,
  input  logic              rate_stb,
  input  logic [RATE_W-1:0] thr_lo,
  input  logic [RATE_W-1:0] thr_hi,
  output part_t             target,
  output logic              thr_ok
);
  logic [RATE_W-1:0] rate_q;

  always_ff @(posedge clk) begin
    if (rst)           rate_q <= '0;
    else if (rate_stb) rate_q <= rate_in;
  end

  always_comb begin
    thr_ok = (thr_lo < thr_hi);
    if (rate_q >= thr_hi)      target = P_HW;
    else if (rate_q >= thr_lo) target = P_MIX;
    else                       target = P_SW;
  end
endmodule

// File: rtl/psc_seq.sv
module psc_seq
  import psc_pkg::*;
#(
  parameter int OVH_CYC  = 1250,
  parameter int BYTE_CYC = 15,
  parameter int BYTES_HM = 30,
  parameter int BYTES_MS = 11,
  parameter int BYTES_HS = 43
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  load_bound,
  input  part_t target,
  input  logic  thr_ok,
  output part_t part_q,
  output part_t src_q,
  output part_t tgt_q,
  output logic  busy_q,
  output logic  en_q
);
  localparam int MAX_AB = (BYTES_HM > BYTES_MS) ? BYTES_HM : BYTES_MS;
  localparam int MAX_B  = (MAX_AB > BYTES_HS) ? MAX_AB : BYTES_HS;
  localparam int MAX_C  = OVH_CYC + MAX_B * BYTE_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cost;
  int               moved;
  logic             start;

  always_comb begin
    case ({part_q, target})
      {P_HW, P_MIX}, {P_MIX, P_HW}: moved = BYTES_HM;
      {P_MIX, P_SW}, {P_SW, P_MIX}: moved = BYTES_MS;
      {P_HW, P_SW},  {P_SW, P_HW}:  moved = BYTES_HS;
      default:                      moved = 0;
    endcase
    cost  = CNT_W'(OVH_CYC + moved * BYTE_CYC);
    start = (phase == PH_RUN) && load_bound && thr_ok && (target != part_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_RUN;
      part_q <= P_HW;
      src_q  <= P_HW;
      tgt_q  <= P_HW;
      cnt    <= '0;
      busy_q <= 1'b0;
      en_q   <= 1'b1;
    end else begin
      case (phase)
        PH_RUN: if (start) begin
          phase  <= PH_LOAD;
          src_q  <= part_q;
          tgt_q  <= target;
          cnt    <= cost - 1'b1;
          busy_q <= 1'b1;
          en_q   <= 1'b0;
        end
        PH_LOAD: begin
          if (cnt == '0) begin
            phase  <= PH_ARM;
            part_q <= tgt_q;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_ARM: if (load_bound) begin
          phase  <= PH_RUN;
          busy_q <= 1'b0;
          en_q   <= 1'b1;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end
endmodule

// File: rtl/psc_rent.sv
module psc_rent
  import psc_pkg::*;
#(
  parameter int ACC_W    = 40,
  parameter int AREA_HW  = 71,
  parameter int AREA_MIX = 41,
  parameter int AREA_SW  = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  part_t            part,
  input  part_t            src,
  input  part_t            tgt,
  output logic [ACC_W-1:0] rent_q
);
  function automatic logic [ACC_W-1:0] area_of(input part_t p);
    case (p)
      P_HW:    return ACC_W'(AREA_HW);
      P_MIX:   return ACC_W'(AREA_MIX);
      P_SW:    return ACC_W'(AREA_SW);
      default: return '0;
    endcase
  endfunction

  logic [ACC_W-1:0] a_src, a_tgt, inc;

  always_comb begin
    a_src = area_of(src);
    a_tgt = area_of(tgt);
    if (busy) inc = (a_src > a_tgt) ? a_src : a_tgt;
    else      inc = area_of(part);
  end

  always_ff @(posedge clk) begin
    if (rst) rent_q <= '0;
    else     rent_q <= rent_q + inc;
  end
endmodule

// File: rtl/part_switch_ctrl.sv
module part_switch_ctrl
  import psc_pkg::*;
#(
  parameter int RATE_W   = 16,
  parameter int ACC_W    = 40,
  parameter int CLK_NS   = 8,
  parameter int OVH_NS   = 10000,
  parameter int BYTE_NS  = 120,
  parameter int AREA_HW  = 71,
  parameter int AREA_MIX = 41,
  parameter int AREA_SW  = 30,
  parameter int BYTES_HM = 30,
  parameter int BYTES_MS = 11,
  parameter int BYTES_HS = 43
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate_in,
  input  logic              rate_stb,
  input  logic [RATE_W-1:0] thr_lo,
  input  logic [RATE_W-1:0] thr_hi,
  input  logic              load_bound,
  output logic [1:0]        part_o,
  output logic              busy_o,
  output logic              enable_o,
  output logic [ACC_W-1:0]  rent_o
);
  localparam int OVH_CYC  = ceil_div(OVH_NS, CLK_NS);
  localparam int BYTE_CYC = ceil_div(BYTE_NS, CLK_NS);

  part_t target, part_q, src_q, tgt_q;
  logic  thr_ok;

  psc_decide #(.RATE_W(RATE_W)) u_decide (
    .clk(clk), .rst(rst), .rate_in(rate_in), .rate_stb(rate_stb),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .target(target), .thr_ok(thr_ok)
  );

  psc_seq #(
    .OVH_CYC(OVH_CYC), .BYTE_CYC(BYTE_CYC),
    .BYTES_HM(BYTES_HM), .BYTES_MS(BYTES_MS), .BYTES_HS(BYTES_HS)
  ) u_seq (
    .clk(clk), .rst(rst), .load_bound(load_bound), .target(target),
    .thr_ok(thr_ok), .part_q(part_q), .src_q(src_q), .tgt_q(tgt_q),
    .busy_q(busy_o), .en_q(enable_o)
  );

  psc_rent #(
    .ACC_W(ACC_W), .AREA_HW(AREA_HW), .AREA_MIX(AREA_MIX), .AREA_SW(AREA_SW)
  ) u_rent (
    .clk(clk), .rst(rst), .busy(busy_o), .part(part_q),
    .src(src_q), .tgt(tgt_q), .rent_q(rent_o)
  );

  assign part_o = part_q;
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
  parameter int RATE_W   = 16,
  parameter int ACC_W    = 40,
  parameter int AREA_HW  = 71,
  parameter int AREA_SW  = 30
) (
  input logic              clk,
  input logic              rst,
  input logic [RATE_W-1:0] thr_lo,
  input logic [RATE_W-1:0] thr_hi,
  input logic              load_bound,
  input logic [1:0]        part_o,
  input logic              busy_o,
  input logic              enable_o,
  input logic [ACC_W-1:0]  rent_o
);
  assert_part_legal_R2: assert property (@(posedge clk) disable iff (rst)
    part_o != 2'd0);

  assert_start_on_bound_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(load_bound));

  assert_part_moves_busy_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(part_o) |-> $past(busy_o));

  assert_enable_inverse_R5: assert property (@(posedge clk) disable iff (rst)
    busy_o != enable_o);

  assert_bad_thr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && (thr_lo >= thr_hi)) |=> !busy_o);

  assert_rent_step_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((rent_o - $past(rent_o)) >= ACC_W'(AREA_SW) &&
                     (rent_o - $past(rent_o)) <= ACC_W'(AREA_HW)));
endmodule

bind part_switch_ctrl psc_checker #(
  .RATE_W(RATE_W), .ACC_W(ACC_W), .AREA_HW(AREA_HW), .AREA_SW(AREA_SW)
) u_chk (
  .clk(clk), .rst(rst), .thr_lo(thr_lo), .thr_hi(thr_hi),
  .load_bound(load_bound), .part_o(part_o), .busy_o(busy_o),
  .enable_o(enable_o), .rent_o(rent_o)
);

// File: tb/tb_part_switch_ctrl.sv
module tb_part_switch_ctrl;
  localparam int RW = 16;
  localparam int AW = 40;
  localparam int OVH = 5;   // 40 ns / 8 ns
  localparam int BPC = 1;   // 8 ns / 8 ns

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [RW-1:0] rate_in = '0;
  logic          rate_stb = 1'b0;
  logic [RW-1:0] thr_lo = 16'd100;
  logic [RW-1:0] thr_hi = 16'd200;
  logic          load_bound = 1'b0;
  logic [1:0]    part_o;
  logic          busy_o, enable_o;
  logic [AW-1:0] rent_o;

  int nchk = 0;
  int nerr = 0;
  int cur  = 1;

  always #4 clk = ~clk;  // 125 MHz

  part_switch_ctrl #(
    .RATE_W(RW), .ACC_W(AW), .CLK_NS(8), .OVH_NS(40), .BYTE_NS(8)
  ) dut (
    .clk(clk), .rst(rst), .rate_in(rate_in), .rate_stb(rate_stb),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .load_bound(load_bound),
    .part_o(part_o), .busy_o(busy_o), .enable_o(enable_o), .rent_o(rent_o)
  );

  function automatic longint area(input int p);
    return (p == 1) ? 71 : (p == 2) ? 41 : 30;
  endfunction

  function automatic int cost(input int a, input int b);
    int by;
    if ((a == 1 && b == 2) || (a == 2 && b == 1))      by = 30;
    else if ((a == 2 && b == 3) || (a == 3 && b == 2)) by = 11;
    else                                               by = 43;
    return OVH + by * BPC;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_rate(input int r);
    rate_in = RW'(r); rate_stb = 1'b1;
    @(negedge clk); rate_stb = 1'b0;
    @(negedge clk);
  endtask

  // one full switch from cur to exp_p, checking cycle timing and rent
  task automatic do_switch(input int r, input bit set_r, input bit mid_en,
                           input int mid_r, input int exp_p);
    int     c;
    longint m, r0;
    if (set_r) set_rate(r);
    c  = cost(cur, exp_p);
    m  = (area(cur) > area(exp_p)) ? area(cur) : area(exp_p);
    chk("R3 idle before switch", busy_o, 0);
    r0 = longint'(rent_o);
    load_bound = 1'b1;
    @(negedge clk); load_bound = 1'b0;
    chk("R5 busy at start", busy_o, 1);
    chk("R5 enable at start", enable_o, 0);
    chk("R8 rent start edge", longint'(rent_o), r0 + area(cur));
    for (int i = 1; i < c; i++) begin
      if (mid_en && i == 3) begin  // R6, R10: rate and boundary mid-load
        rate_in = RW'(mid_r); rate_stb = 1'b1; load_bound = 1'b1;
      end
      @(negedge clk); rate_stb = 1'b0; load_bound = 1'b0;
    end
    chk("R4 old partition at last load cycle", part_o, cur);
    @(negedge clk);
    chk("R4 new partition after load", part_o, exp_p);
    chk("R5 busy until boundary", busy_o, 1);
    chk("R8 rent after load", longint'(rent_o), r0 + area(cur) + c * m);
    @(negedge clk); load_bound = 1'b1;
    @(negedge clk); load_bound = 1'b0;
    chk("R5 busy cleared at boundary", busy_o, 0);
    chk("R5 enable set at boundary", enable_o, 1);
    chk("R8 rent at end", longint'(rent_o), r0 + area(cur) + (c + 2) * m);
    cur = exp_p;
  endtask

  task automatic no_switch(input string req);
    load_bound = 1'b1;
    @(negedge clk); load_bound = 1'b0;
    chk(req, busy_o, 0);
    chk(req, part_o, cur);
  endtask

  initial begin
    longint r0;
    repeat (3) @(negedge clk);
    chk("R1 reset part", part_o, 1);
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset enable", enable_o, 1);
    chk("R1 reset rent", longint'(rent_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rent after first cycle", longint'(rent_o), 71);

    // R2 R4 R6 R10: 1->2, with a mid-load rate 50 and boundary pulse
    do_switch(150, 1, 1, 50, 2);
    // R6: mid-load rate applies at the next boundary, 2->3
    do_switch(0, 0, 0, 0, 3);
    do_switch(250, 1, 0, 0, 1);  // R2 high
    do_switch(99, 1, 0, 0, 3);   // R2 just below low
    do_switch(100, 1, 0, 0, 2);  // R2 low inclusive
    do_switch(200, 1, 0, 0, 1);  // R2 high inclusive

    // R3: target equals current
    set_rate(300);
    no_switch("R3 same target");
    r0 = longint'(rent_o);
    repeat (10) @(negedge clk);
    chk("R8 idle rent", longint'(rent_o), r0 + 10 * 71);

    // R3: target differs but no boundary
    set_rate(50);
    repeat (20) @(negedge clk);
    chk("R3 no boundary", busy_o, 0);

    // R7: invalid thresholds
    thr_lo = 16'd100; thr_hi = 16'd100;
    no_switch("R7 equal thresholds");
    thr_lo = 16'd150; thr_hi = 16'd100;
    no_switch("R7 inverted thresholds");
    thr_lo = 16'd100; thr_hi = 16'd200;

    // R9: strobe and boundary together, old rate (target 1) governs
    set_rate(250);
    rate_in = 16'd50; rate_stb = 1'b1; load_bound = 1'b1;
    @(negedge clk); rate_stb = 1'b0; load_bound = 1'b0;
    chk("R9 coincident strobe no switch", busy_o, 0);
    do_switch(0, 0, 0, 0, 3);    // R9 new rate used at next boundary

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule